// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one accepted READ or WRITE column request into the sequence of column addresses that a memory burst visits. On the cycle a request is taken it looks at a 2-bit burst-length mode code and at the A12 bit that travelled with the command. From these it settles on a burst of 4 beats or 8 beats. It then issues one column address per clock, flags the final beat and reports the length in force.

The addresses never leave an aligned block whose size equals the burst length. The column bits above that block stay frozen. The low bits count upward from the starting column and wrap back to the bottom of the same block. Only sequential ordering is produced. The sequencer takes a new request only while it is idle, so back-to-back bursts are separated by one idle cycle.

Control is a two-state machine. ST_IDLE waits with `cmd_ready` high. Transition T_ACCEPT (`cmd_valid` seen in ST_IDLE) latches the start column and the decided length and moves to ST_RUN. In ST_RUN, transition T_STEP advances the beat index by one per cycle. Transition T_DONE, taken on the final beat, returns to ST_IDLE.

Top module: `col_burst_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `cmd_ready` is 1 and `beat_valid`, `beat_last` and `burst_len` are 0.
- R2: A request is taken at a rising edge where `cmd_valid` and `cmd_ready` are both 1. Beats start on the next cycle and `beat_valid` then stays high for exactly the burst length in consecutive cycles.
- R3: Mode code 2'b00 and mode code 2'b11 both give an 8-beat burst whatever `cmd_a12` is.
- R4: Mode code 2'b10 gives a 4-beat burst whatever `cmd_a12` is.
- R5: Mode code 2'b01 picks the length per request: `cmd_a12` = 0 gives 4 beats and `cmd_a12` = 1 gives 8 beats.
- R6: In an 8-beat burst, beat k (k = 0..7) carries column bits [COL_W-1:3] equal to those of the start column, and low bits [2:0] = (start[2:0] + k) mod 8.
- R7: In a 4-beat burst, beat k (k = 0..3) carries column bits [COL_W-1:2] equal to those of the start column, and low bits [1:0] = (start[1:0] + k) mod 4.
- R8: `beat_last` is 1 only on the final beat of a burst (beat 3 of a 4-beat burst, beat 7 of an 8-beat burst) and is 0 in every other cycle.
- R9: While `beat_valid` is 1, `burst_len` shows 4'd4 or 4'd8 for the burst in progress and holds it constant. While `beat_valid` is 0 it shows 4'd0.
- R10: `cmd_ready` is 0 from the first beat through the final beat, and it returns to 1 on the cycle after the final beat. A `cmd_valid` seen while `cmd_ready` is 0 has no effect on the beats or on their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Request present this cycle |
| cmd_col | input | COL_W | Starting column of the request |
| cmd_mode | input | 2 | Burst-length mode code (00 fixed 8, 01 per-request, 10 fixed 4, 11 treated as fixed 8) |
| cmd_a12 | input | 1 | Per-request length select used with mode 01 |
| cmd_ready | output | 1 | High when idle and able to take a request |
| beat_valid | output | 1 | A beat address is present this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| burst_len | output | 4 | Length of the burst in progress, 0 when idle |

## Verification
The bench starts bursts just below a block boundary (low bits 5 and 3), at the top of the column range and at column zero. A design that carried into the upper bits instead of wrapping would step into the neighbouring block, or roll over past the top column. All four mode codes are tried with both values of A12. This catches a design that ignores A12 in mode 01, honours it in the fixed modes, or gives the reserved code a 4-beat length. `cmd_valid` is held high through whole bursts, which exposes a design that restarts or overwrites its start column in mid-burst. The exact cycle of `beat_last` and of the return of `cmd_ready` is compared, so an off-by-one beat count or a missing idle gap shows as a mismatch.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst-length mode codes as seen on cmd_mode
    typedef enum logic [1:0] {
        BL_MODE_FIX8  = 2'b00,
        BL_MODE_OTF   = 2'b01,
        BL_MODE_CHOP4 = 2'b10,
        BL_MODE_RSVD  = 2'b11
    } bl_mode_e;

    // Sequencer control states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam int unsigned LEN_LONG  = 8;
    localparam int unsigned LEN_SHORT = 4;
    localparam int unsigned IDX_W     = $clog2(LEN_LONG);
    localparam int unsigned LEN_W     = $clog2(LEN_LONG) + 1;

endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
    import burst_seq_pkg::*;
(
    input  logic [1:0] mode_code,
    input  logic       a12,
    output logic       len8
);

    always_comb begin
        len8 = 1'b1;
        unique case (bl_mode_e'(mode_code))
            BL_MODE_FIX8:  len8 = 1'b1;
            BL_MODE_OTF:   len8 = a12;
            BL_MODE_CHOP4: len8 = 1'b0;
            BL_MODE_RSVD:  len8 = 1'b1;
        endcase
    end

endmodule

// File: rtl/burst_wrap_addr.sv
module burst_wrap_addr
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
)(
    input  logic [COL_W-1:0] base_col,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic             len8,
    output logic [COL_W-1:0] col
);

    localparam int unsigned SHORT_W = $clog2(LEN_SHORT);

    logic [IDX_W-1:0]   sum_long;
    logic [SHORT_W-1:0] sum_short;

    always_comb begin
        sum_long  = base_col[IDX_W-1:0] + beat_idx;
        sum_short = base_col[SHORT_W-1:0] + beat_idx[SHORT_W-1:0];
        col = base_col;
        if (len8) begin
            col[IDX_W-1:0] = sum_long;
        end else begin
            col[SHORT_W-1:0] = sum_short;
        end
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             len8_in,
    output logic             cmd_ready,
    output logic             load,
    output logic             beat_valid,
    output logic             beat_last,
    output logic [IDX_W-1:0] beat_idx,
    output logic             len8_q
);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] final_idx;
    logic             at_final;

    assign final_idx = len8_q ? IDX_W'(LEN_LONG - 1) : IDX_W'(LEN_SHORT - 1);
    assign at_final  = (state_q == ST_RUN) && (idx_q == final_idx);
    assign beat_idx  = idx_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_ACCEPT, T_STEP, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_RUN;
            ST_RUN:  if (at_final)  state_d = ST_IDLE;
        endcase
    end

    // Beat index and latched length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            len8_q <= 1'b1;
        end else if (state_q == ST_IDLE && cmd_valid) begin
            idx_q  <= '0;
            len8_q <= len8_in;
        end else if (state_q == ST_RUN) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cmd_ready  = 1'b0;
        load       = 1'b0;
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                load      = cmd_valid;
            end
            ST_RUN: begin
                beat_valid = 1'b1;
                beat_last  = at_final;
            end
        endcase
    end

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_valid && !cmd_ready && beat_idx == '0)); // R2

    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> beat_valid); // R2

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |=> (cmd_ready && !beat_valid)); // R10

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> $stable(len8_q)); // R9

    AST_LAST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> (beat_idx == IDX_W'(LEN_SHORT - 1) || beat_idx == IDX_W'(LEN_LONG - 1))); // R8

endmodule

// File: rtl/col_burst_seq.sv
module col_burst_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       cmd_mode,
    input  logic             cmd_a12,
    output logic             cmd_ready,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last,
    output logic [LEN_W-1:0] burst_len
);

    logic             len8_now;
    logic             len8_q;
    logic             load;
    logic [IDX_W-1:0] beat_idx;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] wrap_col;

    burst_len_dec u_len_dec (
        .mode_code (cmd_mode),
        .a12       (cmd_a12),
        .len8      (len8_now)
    );

    burst_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .len8_in    (len8_now),
        .cmd_ready  (cmd_ready),
        .load       (load),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .beat_idx   (beat_idx),
        .len8_q     (len8_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load) begin
            start_q <= cmd_col;
        end
    end

    burst_wrap_addr #(.COL_W(COL_W)) u_wrap (
        .base_col (start_q),
        .beat_idx (beat_idx),
        .len8     (len8_q),
        .col      (wrap_col)
    );

    assign beat_col  = beat_valid ? wrap_col : '0;
    assign burst_len = !beat_valid ? '0 :
                       (len8_q ? LEN_W'(LEN_LONG) : LEN_W'(LEN_SHORT));

    AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (beat_col == $past(cmd_col))); // R6

    AST_WRAP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && burst_len == LEN_W'(LEN_LONG))
        |=> (beat_col[2:0] == 3'($past(beat_col[2:0]) + 3'd1))); // R6

    AST_WRAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && burst_len == LEN_W'(LEN_SHORT))
        |=> (beat_col[1:0] == 2'($past(beat_col[1:0]) + 2'd1)
             && beat_col[2] == $past(beat_col[2]))); // R7

    AST_LEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (burst_len == LEN_W'(LEN_SHORT) || burst_len == LEN_W'(LEN_LONG))); // R9

    generate
        if (COL_W > IDX_W) begin : g_upper_chk
            AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (beat_valid && !beat_last)
                |=> (beat_col[COL_W-1:IDX_W] == $past(beat_col[COL_W-1:IDX_W]))); // R6
        end
    endgenerate

endmodule

// File: tb/test_col_burst_seq.sv
module test_col_burst_seq;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmd_valid;
    logic [COL_W-1:0] cmd_col;
    logic [1:0]       cmd_mode;
    logic             cmd_a12;
    logic             cmd_ready;
    logic             beat_valid;
    logic [COL_W-1:0] beat_col;
    logic             beat_last;
    logic [3:0]       burst_len;

    always #2 clk = ~clk;

    col_burst_seq #(.COL_W(COL_W)) i_col_burst_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_col    (cmd_col),
        .cmd_mode   (cmd_mode),
        .cmd_a12    (cmd_a12),
        .cmd_ready  (cmd_ready),
        .beat_valid (beat_valid),
        .beat_col   (beat_col),
        .beat_last  (beat_last),
        .burst_len  (burst_len)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model: expected beats still to come
    int q_col[$];
    int q_last[$];
    int q_len[$];
    int q_mode[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string len_req(input int mode);
        if (mode == 1) return "R5";
        if (mode == 2) return "R4";
        return "R3";
    endfunction

    function automatic int model_len(input int mode, input bit a12);
        if (mode == 1) return a12 ? 8 : 4;
        if (mode == 2) return 4;
        return 8;
    endfunction

    // One clock: compare now, drive, advance model, step to the next falling edge
    task automatic cycle(input bit v, input int col, input int mode, input bit a12);
        bit exp_v;
        exp_v = (q_col.size() != 0);
        check(beat_valid == exp_v, "R2 beat_valid", int'(beat_valid), int'(exp_v));
        check(cmd_ready == !exp_v, "R10 cmd_ready", int'(cmd_ready), int'(!exp_v));
        if (exp_v) begin
            check(int'(beat_col) == q_col[0], (q_len[0] == 8) ? "R6 beat_col" : "R7 beat_col",
                  int'(beat_col), q_col[0]);
            check(int'(beat_last) == q_last[0], "R8 beat_last", int'(beat_last), q_last[0]);
            check(int'(burst_len) == q_len[0], {len_req(q_mode[0]), " burst_len"},
                  int'(burst_len), q_len[0]);
        end else begin
            check(burst_len == 4'd0, "R9 idle burst_len", int'(burst_len), 0);
            check(beat_last == 1'b0, "R8 idle beat_last", int'(beat_last), 0);
        end

        cmd_valid = v;
        cmd_col   = COL_W'(col);
        cmd_mode  = 2'(mode);
        cmd_a12   = a12;

        if (exp_v) begin
            void'(q_col.pop_front());
            void'(q_last.pop_front());
            void'(q_len.pop_front());
            void'(q_mode.pop_front());
        end else if (v) begin
            int len, c, base, off;
            len  = model_len(mode, a12);
            c    = col % (1 << COL_W);
            base = c - (c % len);
            off  = c % len;
            for (int k = 0; k < len; k++) begin
                q_col.push_back(base + ((off + k) % len));
                q_last.push_back((k == len - 1) ? 1 : 0);
                q_len.push_back(len);
                q_mode.push_back(mode);
            end
        end

        @(posedge clk);
        @(negedge clk);
    endtask

    // Issue one request, keep cmd_valid high with junk while it runs, then drain
    task automatic burst(input int col, input int mode, input bit a12);
        cycle(1'b1, col, mode, a12);
        for (int i = 0; i < 9; i++) begin
            cycle(1'b1, (col + 37 * (i + 1)) % 1024, (mode + 1) % 4, ~a12);
            if (q_col.size() == 0) break;
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        cmd_valid = 1'b1;
        cmd_col   = '0;
        cmd_mode  = 2'b00;
        cmd_a12   = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1 during reset
        check(cmd_ready == 1'b1,  "R1 cmd_ready",  int'(cmd_ready), 1);
        check(beat_valid == 1'b0, "R1 beat_valid", int'(beat_valid), 0);
        check(beat_last == 1'b0,  "R1 beat_last",  int'(beat_last), 0);
        check(burst_len == 4'd0,  "R1 burst_len",  int'(burst_len), 0);
        cmd_valid = 1'b0;
        rst_n     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1 first cycle out of reset (no request taken during reset)
        check(cmd_ready == 1'b1,  "R1 cmd_ready after reset",  int'(cmd_ready), 1);
        check(beat_valid == 1'b0, "R1 beat_valid after reset", int'(beat_valid), 0);

        // R3: fixed 8, wrap from low bits 5; A12 ignored
        burst(10'h2F5, 0, 1'b0);
        burst(10'h2F5, 0, 1'b1);
        // R3: reserved code behaves as fixed 8
        burst(10'h3FF, 3, 1'b0);
        burst(10'h000, 3, 1'b1);
        // R4: chop 4, wrap from low bits 3 with bit 2 set; A12 ignored
        burst(10'h1E7, 2, 1'b1);
        burst(10'h1E7, 2, 1'b0);
        // R5: per-request selection
        burst(10'h0AB, 1, 1'b0);
        burst(10'h0AB, 1, 1'b1);
        burst(10'h3FE, 1, 1'b0);
        // R10: back-to-back offers without drain
        for (int i = 0; i < 20; i++) cycle(1'b1, 10'h155 + i, i % 4, i[1]);
        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            cycle(($urandom % 3) != 0, int'($urandom % 1024), int'($urandom % 4), 1'($urandom));
        end
        for (int i = 0; i < 10; i++) cycle(1'b0, 0, 0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule